// File: doc/BRIEF.md
# Half-Rate PRBS15 Error Counter with Serial Shift-Out

This block measures bit errors on a receive path that delivers two bits per clock. A local pseudo-random generator with a period of 2^15−1 runs two steps every clock and produces the pair of bits the receiver should have seen. Each clock of an open measurement window, the two received bits are compared with that pair, and every mismatching bit adds one to an 11-bit error counter. The counter stops at its maximum value and does not wrap.

A clear pulse starts a measurement. It zeroes the counter, loads the seed into the generator, and opens a window of a programmed number of clocks. When the window closes, a done flag rises and the count stays fixed. The result leaves the block only through a serial port. A read request captures the count into a shift register. Each later pulse of the serial enable moves the next bit, most significant first, onto the data output. A second flag shows that all bits have been shifted out.

Top module: `prbs_ber_monitor`

## Requirements
- R1: The reference is a Fibonacci generator for x^15 + x^14 + 1. Each step forms b = s[14] ^ s[13] and moves the state to {s[13:0], b}. The state starts from the 15-bit SEED, which defaults to 15'h7FFF. In each window clock the first step's b is the expected bit for rx_bits_i[0] and the second step's b is the expected bit for rx_bits_i[1]. The generator advances two steps in every window clock and holds still outside the window.
- R2: In each window clock the error count rises by the number of lanes whose received bit differs from its expected bit: 0, 1 or 2.
- R3: The error count saturates at 2047 and never wraps or decreases until the next clear.
- R4: After a clear with length N, exactly N clocks are compared. meas_done_o is low during those clocks and high from the clock after the last one. After that, received bits do not change the count. N = 0 compares no clocks and raises meas_done_o at once.
- R5: A clear_i pulse zeroes the count, reloads SEED, latches win_len_i and restarts the window, including while a window is still open.
- R6: A read_req_i pulse while no readout is in progress captures the count. On the next clock sdata_o shows count bit 10. After k serial enable pulses it shows bit 10−k. On the 11th pulse rd_done_o rises and sdata_o returns to 0.
- R7: A read_req_i during a readout is ignored. A sclk_en_i with no readout in progress has no effect.
- R8: After reset, sdata_o, meas_done_o and rd_done_o are 0 and no window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Starts a measurement: zeroes the count, reloads the seed, opens the window |
| win_len_i | input | 16 | Window length in clocks, latched on clear_i |
| rx_bits_i | input | 2 | Received bits; bit 0 is the earlier bit in time |
| read_req_i | input | 1 | Captures the count and starts the serial readout |
| sclk_en_i | input | 1 | Serial enable; each pulse shifts out one bit |
| sdata_o | output | 1 | Serial count output, MSB first |
| meas_done_o | output | 1 | The measurement window has closed |
| rd_done_o | output | 1 | All 11 bits have been shifted out |

## Verification
The bench never reads the counter directly, so any fault in the internal state has to show up in the serial stream. A generator that is out of step or seeded wrongly produces a large non-zero count in a window of error-free data, and that shows on the next readout. A window counter that is off by one either picks up or drops an injected error on the final clock, and it also moves the rise of meas_done_o by one clock, which the bench checks on the exact clock. A wrong shift order or a wrong bit count shows up within 11 enable pulses as a bad bit, or as rd_done_o rising on the wrong pulse.

// File: rtl/ber_pkg.sv
package ber_pkg;
  localparam int unsigned PRBS_W  = 15;
  localparam int unsigned TAP_HI  = 14;
  localparam int unsigned TAP_LO  = 13;
  localparam logic [PRBS_W-1:0] DEF_SEED = 15'h7FFF;
  localparam int unsigned DEF_CNT_W = 11;
  localparam int unsigned DEF_WIN_W = 16;
  localparam int unsigned DEF_LANES = 2;
endpackage

// File: rtl/prbs_multi_step.sv
module prbs_multi_step
  import ber_pkg::*;
#(
  parameter int unsigned LANES = DEF_LANES,
  parameter logic [PRBS_W-1:0] SEED = DEF_SEED
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  output logic [LANES-1:0] exp_o
);
  logic [PRBS_W-1:0] state_q, state_nxt;

  always_comb begin
    state_nxt = state_q;
    exp_o     = '0;
    for (int k = 0; k < int'(LANES); k++) begin
      exp_o[k]  = state_nxt[TAP_HI] ^ state_nxt[TAP_LO];
      state_nxt = {state_nxt[PRBS_W-2:0], exp_o[k]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (load_i) state_q <= SEED;
    else if (step_i) state_q <= state_nxt;
  end

  // R1: a zero state would lock the generator
  a_r1_state_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  // R1: the state holds outside the window
  a_r1_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(state_q));
endmodule

// File: rtl/err_accum.sv
module err_accum
  import ber_pkg::*;
#(
  parameter int unsigned LANES = DEF_LANES,
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic [LANES-1:0] rx_i,
  input  logic [LANES-1:0] exp_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [LANES-1:0] miss;
  logic [SUM_W-1:0] inc, sum;
  logic [CNT_W-1:0] cnt_q;

  assign miss = rx_i ^ exp_i;

  always_comb begin
    inc = '0;
    for (int k = 0; k < int'(LANES); k++) inc = inc + SUM_W'(miss[k]);
    sum = {1'b0, cnt_q} + inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clear_i)   cnt_q <= '0;
    else if (en_i)      cnt_q <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;

  a_r3_no_decrease: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> cnt_q >= $past(cnt_q));
  a_r5_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0);
  a_r2_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (cnt_q - $past(cnt_q)) <= CNT_W'(LANES));
endmodule

// File: rtl/win_ctrl.sv
module win_ctrl #(
  parameter int unsigned WIN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [WIN_W-1:0] len_i,
  output logic             run_o,
  output logic             done_o
);
  logic [WIN_W-1:0] len_q, cyc_q;
  logic             run_q, done_q;
  logic             last;

  assign last = (cyc_q == len_q - WIN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      cyc_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (clear_i) begin
      len_q  <= len_i;
      cyc_q  <= '0;
      run_q  <= (len_i != '0);
      done_q <= (len_i == '0);
    end else if (run_q) begin
      cyc_q <= cyc_q + WIN_W'(1);
      if (last) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign run_o  = run_q;
  assign done_o = done_q;

  a_r4_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_q && done_q));
  a_r4_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && last && !clear_i) |=> done_q);
  a_r4_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !clear_i) |=> done_q);
endmodule

// File: rtl/serial_out.sv
module serial_out #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             shift_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             sdata_o,
  output logic             done_o
);
  localparam int unsigned IDX_W = $clog2(CNT_W + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CNT_W - 1);

  logic [CNT_W-1:0] sh_q;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (!busy_q && req_i) begin
      sh_q   <= val_i;
      idx_q  <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q && shift_i) begin
      sh_q  <= {sh_q[CNT_W-2:0], 1'b0};
      idx_q <= idx_q + IDX_W'(1);
      if (idx_q == LAST_IDX) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign sdata_o = sh_q[CNT_W-1];
  assign done_o  = done_q;

  a_r6_hold_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !shift_i) |=> $stable(sdata_o));
  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !req_i) |=> ($stable(sdata_o) && $stable(done_q)));
  a_r6_empty_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> !sdata_o);
endmodule

// File: rtl/prbs_ber_monitor.sv
module prbs_ber_monitor
  import ber_pkg::*;
#(
  parameter int unsigned WIN_W = DEF_WIN_W,
  parameter int unsigned CNT_W = DEF_CNT_W,
  parameter int unsigned LANES = DEF_LANES,
  parameter logic [PRBS_W-1:0] SEED = DEF_SEED
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [WIN_W-1:0] win_len_i,
  input  logic [LANES-1:0] rx_bits_i,
  input  logic             read_req_i,
  input  logic             sclk_en_i,
  output logic             sdata_o,
  output logic             meas_done_o,
  output logic             rd_done_o
);
  logic             run;
  logic [LANES-1:0] exp_bits;
  logic [CNT_W-1:0] err_cnt;

  win_ctrl #(.WIN_W(WIN_W)) u_win (
    .clk_i, .rst_ni, .clear_i,
    .len_i  (win_len_i),
    .run_o  (run),
    .done_o (meas_done_o)
  );

  prbs_multi_step #(.LANES(LANES), .SEED(SEED)) u_gen (
    .clk_i, .rst_ni,
    .load_i (clear_i),
    .step_i (run),
    .exp_o  (exp_bits)
  );

  err_accum #(.LANES(LANES), .CNT_W(CNT_W)) u_acc (
    .clk_i, .rst_ni, .clear_i,
    .en_i  (run),
    .rx_i  (rx_bits_i),
    .exp_i (exp_bits),
    .cnt_o (err_cnt)
  );

  serial_out #(.CNT_W(CNT_W)) u_ser (
    .clk_i, .rst_ni,
    .req_i   (read_req_i),
    .shift_i (sclk_en_i),
    .val_i   (err_cnt),
    .sdata_o (sdata_o),
    .done_o  (rd_done_o)
  );

  a_r4_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_done_o && !clear_i) |=> $stable(err_cnt));
endmodule

// File: tb/prbs_ber_monitor_bench.sv
module prbs_ber_monitor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic [15:0] win_len = '0;
  logic [1:0]  rx = '0;
  logic        rd_req = 1'b0;
  logic        sclk_en = 1'b0;
  logic        sdata, meas_done, rd_done;

  int checks = 0, errors = 0;
  int exp_q[$];
  logic [14:0] mstate;

  always #10 clk = ~clk;

  prbs_ber_monitor u_prbs_ber_monitor (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .win_len_i(win_len),
    .rx_bits_i(rx), .read_req_i(rd_req), .sclk_en_i(sclk_en),
    .sdata_o(sdata), .meas_done_o(meas_done), .rd_done_o(rd_done)
  );

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Model of R1: x^15+x^14+1, feedback s[14]^s[13], bit0 first
  function automatic logic [1:0] next_pair();
    logic [1:0] p;
    for (int k = 0; k < 2; k++) begin
      p[k]   = mstate[14] ^ mstate[13];
      mstate = {mstate[13:0], p[k]};
    end
    return p;
  endfunction

  // Driver: runs one window, inj(k) = error mask for cycle k; pushes expected count
  task automatic run_window(int n, int mode, int extra);
    int total = 0;
    @(negedge clk);
    clear = 1'b1; win_len = 16'(n);
    mstate = 15'h7FFF;
    @(negedge clk);
    clear = 1'b0;
    if (n == 0) chk("R4 zero-length done", int'(meas_done), 1);
    for (int k = 0; k < n; k++) begin
      logic [1:0] m;
      case (mode)
        0: m = 2'b00;
        1: m = (k == 3) ? 2'b01 : (k == 7) ? 2'b10 : (k == n-1) ? 2'b11 : 2'b00;
        2: m = 2'b11;
        default: m = (k < n-1) ? 2'b11 : 2'b01;
      endcase
      total += int'(m[0]) + int'(m[1]);
      rx = next_pair() ^ m;
      if (k == n-1) chk("R4 done low in last window clock", int'(meas_done), 0);
      @(negedge clk);
    end
    chk("R4 done after window", int'(meas_done), 1);
    for (int k = 0; k < extra; k++) begin
      rx = ~rx;
      @(negedge clk);
    end
    exp_q.push_back(total > 2047 ? 2047 : total);
  endtask

  // Monitor: shifts the count out and compares with the scoreboard
  task automatic read_and_compare(string req, bit poke_busy);
    int got = 0, expv;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    for (int i = 0; i < 11; i++) begin
      got = (got << 1) | int'(sdata);
      if (i < 10 || !poke_busy) chk("R6 rd_done low mid-read", int'(rd_done), 0);
      sclk_en = 1'b1;
      if (poke_busy && i == 4) rd_req = 1'b1; // R7: ignored while busy
      @(negedge clk);
      sclk_en = 1'b0; rd_req = 1'b0;
      @(negedge clk);
    end
    chk("R6 rd_done after 11 pulses", int'(rd_done), 1);
    chk("R6 sdata zero after readout", int'(sdata), 0);
    expv = exp_q.pop_front();
    chk(req, got, expv);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset sdata", int'(sdata), 0);
    chk("R8 reset meas_done", int'(meas_done), 0);
    chk("R8 reset rd_done", int'(rd_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: sclk_en while idle does nothing
    sclk_en = 1'b1; @(negedge clk); sclk_en = 1'b0; @(negedge clk);
    chk("R7 idle shift no effect rd_done", int'(rd_done), 0);
    chk("R7 idle shift no effect sdata", int'(sdata), 0);

    run_window(20, 0, 0);
    read_and_compare("R1 clean pattern gives zero", 1'b0);

    run_window(40, 1, 6);
    read_and_compare("R2 lane errors counted, R4 window frozen", 1'b0);

    // R5: abort a window midway, restart with clean data
    @(negedge clk); clear = 1'b1; win_len = 16'd50; @(negedge clk); clear = 1'b0;
    for (int k = 0; k < 10; k++) begin rx = 2'b11; @(negedge clk); end
    chk("R5 done low while window open", int'(meas_done), 0);
    run_window(8, 0, 0);
    read_and_compare("R5 clear reloads seed and zeroes count", 1'b0);

    run_window(722, 3, 0);
    read_and_compare("R6 MSB-first value 1443, R7 busy request", 1'b1);

    run_window(1100, 2, 0);
    read_and_compare("R3 saturation at 2047", 1'b0);

    run_window(0, 0, 3);
    read_and_compare("R4 zero-length window", 1'b0);

    sclk_en = 1'b1; @(negedge clk); sclk_en = 1'b0; @(negedge clk);
    chk("R7 idle shift keeps rd_done", int'(rd_done), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule